// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Keeper with Snapshot Freeze

This block counts time and date in packed BCD, from hundredths of a second up to a two-digit year, driven by a one-cycle 100 Hz tick. The host never reads the running counters directly. It sees a 16-byte register window that behaves like ordinary memory. The clock bytes in that window are a snapshot copy. The block refreshes every clock byte of the snapshot on one clock edge, once per elapsed second.

Two control bits let the host stop the snapshot from changing. A read-hold bit keeps a stable copy on view while the counters keep running. A set-time bit also stops refreshes, so the host can write new time values into the window. When the set-time bit is cleared, those values are loaded into the counters on the next tick. A stop bit held in the seconds byte halts counting altogether. Register bits that have no clock meaning are plain read/write storage.

Top module: `bcd_rtc_core`

## Requirements
- R1: After reset the window reads as follows: offset 1 (hundredths) 00, offset 9 (seconds) 00, offset 10 (minutes) 00, offset 11 (hours) 00, offset 12 (weekday) 01, offset 13 (date) 01, offset 14 (month) 01, offset 15 (year) 00, offset 8 (control) 00, and every other offset 00.
- R2: On each tick, hundredths count 00–99 in BCD, and the wrap from 99 to 00 advances the seconds. Seconds and minutes run 00–59, hours run 00–23, date runs 01–31, month runs 01–12 and year runs 00–99. Each wrap advances the next field up.
- R3: The weekday field (offset 12, bits 2:0) advances on every hour wrap and goes from 07 back to 01, regardless of the date.
- R4: On the tick that completes a second, all clock bytes of the snapshot take the new counter values on the same clock edge. On no other tick does the snapshot change, so the hundredths byte reads 00 after any refresh.
- R5: While control bit 6 is 1, the snapshot is not refreshed and the counters keep running. After the bit is cleared, the next completed second refreshes the snapshot with the true time.
- R6: If a host write sets control bit 6 in the same cycle as a tick that completes a second, that refresh still takes place, and the freeze applies from the next second on.
- R7: While control bit 7 is 1, the snapshot is not refreshed and the host may write the clock bytes. A write that changes bit 7 from 1 to 0 arms a load. The next tick then copies the clock fields of the window into the counters without advancing them. Counting resumes on the following tick.
- R8: While bit 7 of the seconds byte is 1, ticks neither advance the counters nor refresh the snapshot. After the bit is cleared, counting resumes from the held value.
- R9: Bits with no clock role keep what the host wrote, and refreshes do not change them. These are all of offsets 0 and 2–7, control bits 5:0, minutes bit 7, hours bits 7:6, weekday bits 7:3, date bits 7:6 and month bits 7:5.
- R10: The read data equals the byte at the addressed offset, in the same cycle, while read-enable is 1, and is 00 while read-enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_100hz | input | 1 | One-cycle pulse, 100 times per second |
| reg_addr | input | 4 | Register window offset |
| reg_wdata | input | 8 | Host write data |
| reg_we | input | 1 | Host write strobe |
| reg_re | input | 1 | Host read enable |
| reg_rdata | output | 8 | Read data of the addressed byte |

## Verification
The bench builds the block with its default window of sixteen bytes and eight BCD fields. The tick is driven by the bench, so whole seconds cost only two hundred cycles. Setting the time through the write path to 23:59:58 on date 31 of month 12, year 99, weekday 7, brings every carry of the chain into reach within two seconds. The bench also forces a control write and a second-completing tick into the same cycle to exercise the freeze-during-refresh ordering.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int NFIELD     = 8;
    localparam int REG_COUNT  = 16;
    localparam int ADDR_W     = $clog2(REG_COUNT);
    localparam int BYTE_W     = 8;
    localparam int CTRL_ADDR  = 8;
    localparam int SEC_ADDR   = 9;
    localparam int SET_BIT    = 7;
    localparam int HOLD_BIT   = 6;
    localparam int STOP_BIT   = 7;

    typedef logic [NFIELD-1:0][BYTE_W-1:0]    field_vec_t;
    typedef logic [REG_COUNT-1:0][BYTE_W-1:0] window_t;

    typedef struct packed {
        window_t win;
        logic    load_pend;
    } core_st_t;

    // Field order: 0 hundredths, 1 seconds, 2 minutes, 3 hours,
    // 4 weekday, 5 date, 6 month, 7 year
    function automatic logic [ADDR_W-1:0] field_addr(input int i);
        case (i)
            0:       return ADDR_W'(1);
            1:       return ADDR_W'(9);
            2:       return ADDR_W'(10);
            3:       return ADDR_W'(11);
            4:       return ADDR_W'(12);
            5:       return ADDR_W'(13);
            6:       return ADDR_W'(14);
            default: return ADDR_W'(15);
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] field_min(input int i);
        case (i)
            4, 5, 6: return 8'h01;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] field_max(input int i);
        case (i)
            1, 2:    return 8'h59;
            3:       return 8'h23;
            4:       return 8'h07;
            5:       return 8'h31;
            6:       return 8'h12;
            default: return 8'h99;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] field_mask(input int i);
        case (i)
            1, 2:    return 8'h7F;
            3, 5:    return 8'h3F;
            4:       return 8'h07;
            6:       return 8'h1F;
            default: return 8'hFF;
        endcase
    endfunction

    // Field whose wrap advances field i
    function automatic int field_src(input int i);
        case (i)
            5:       return 3;
            6:       return 5;
            7:       return 6;
            default: return (i > 0) ? i - 1 : 0;
        endcase
    endfunction

    function automatic window_t reset_window();
        window_t w;
        w = '0;
        for (int i = 0; i < NFIELD; i++) begin
            w[field_addr(i)] = field_min(i);
        end
        return w;
    endfunction

endpackage

// File: rtl/rtc_bcd_field.sv
module rtc_bcd_field
    import rtc_pkg::*;
#(
    parameter logic [BYTE_W-1:0] MIN_V = 8'h00,
    parameter logic [BYTE_W-1:0] MAX_V = 8'h59
) (
    input  logic [BYTE_W-1:0] cur,
    input  logic              inc,
    output logic [BYTE_W-1:0] nxt,
    output logic              at_max
);

    localparam int NIB = BYTE_W / 2;

    logic [BYTE_W-1:0] stepped;

    always_comb begin
        at_max = (cur >= MAX_V);
        if (cur[NIB-1:0] >= NIB'(9)) begin
            stepped = {cur[BYTE_W-1:NIB] + NIB'(1), NIB'(0)};
        end else begin
            stepped = {cur[BYTE_W-1:NIB], cur[NIB-1:0] + NIB'(1)};
        end
        if (!inc) begin
            nxt = cur;
        end else if (at_max) begin
            nxt = MIN_V;
        end else begin
            nxt = stepped;
        end
    end

endmodule

// File: rtl/rtc_time_chain.sv
module rtc_time_chain
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       advance,
    input  logic       load,
    input  field_vec_t load_val,
    output field_vec_t cnt_q,
    output field_vec_t cnt_d,
    output logic       sec_step
);

    logic [NFIELD-1:0] inc;
    logic [NFIELD-1:0] at_max;
    field_vec_t        nxt;

    always_comb begin
        inc[0] = advance;
        for (int i = 1; i < NFIELD; i++) begin
            inc[i] = inc[field_src(i)] && at_max[field_src(i)];
        end
    end

    for (genvar g = 0; g < NFIELD; g++) begin : g_field
        rtc_bcd_field #(
            .MIN_V (field_min(g)),
            .MAX_V (field_max(g))
        ) u_field (
            .cur    (cnt_q[g]),
            .inc    (inc[g]),
            .nxt    (nxt[g]),
            .at_max (at_max[g])
        );
    end

    assign sec_step = inc[1];

    always_comb begin
        for (int i = 0; i < NFIELD; i++) begin
            cnt_d[i] = load ? (load_val[i] & field_mask(i)) : nxt[i];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NFIELD; i++) begin
                cnt_q[i] <= field_min(i);
            end
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/bcd_rtc_core.sv
module bcd_rtc_core
    import rtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_100hz,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    input  logic              reg_we,
    input  logic              reg_re,
    output logic [BYTE_W-1:0] reg_rdata
);

    localparam window_t WIN_RESET = reset_window();

    core_st_t   st_d, st_q;
    window_t    win_q;
    logic       load_pend_q;
    field_vec_t load_val, cnt_q, cnt_d;
    logic       sec_step, advance, load, freeze, osc_stop, refresh;

    assign win_q       = st_q.win;
    assign load_pend_q = st_q.load_pend;

    always_comb begin
        freeze   = st_q.win[CTRL_ADDR][SET_BIT] | st_q.win[CTRL_ADDR][HOLD_BIT];
        osc_stop = st_q.win[SEC_ADDR][STOP_BIT];
        load     = tick_100hz && st_q.load_pend;
        advance  = tick_100hz && !osc_stop && !st_q.load_pend;
        for (int i = 0; i < NFIELD; i++) begin
            load_val[i] = st_q.win[field_addr(i)];
        end
    end

    rtc_time_chain u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .advance  (advance),
        .load     (load),
        .load_val (load_val),
        .cnt_q    (cnt_q),
        .cnt_d    (cnt_d),
        .sec_step (sec_step)
    );

    assign refresh = sec_step && !freeze;

    always_comb begin
        st_d = st_q;
        if (refresh) begin
            for (int i = 0; i < NFIELD; i++) begin
                st_d.win[field_addr(i)] = (st_q.win[field_addr(i)] & ~field_mask(i))
                                        | (cnt_d[i] & field_mask(i));
            end
        end
        if (load) begin
            st_d.load_pend = 1'b0;
        end
        if (reg_we) begin
            st_d.win[reg_addr] = reg_wdata;
            if (reg_addr == ADDR_W'(CTRL_ADDR) && st_q.win[CTRL_ADDR][SET_BIT]
                && !reg_wdata[SET_BIT]) begin
                st_d.load_pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.win       <= WIN_RESET;
            st_q.load_pend <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = reg_re ? st_q.win[reg_addr] : '0;
    end

endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk
    import rtc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       reg_we,
    input logic       tick,
    input logic       advance,
    input logic       load_pend,
    input window_t    win,
    input field_vec_t cnt
);

    AST_HOLD_FREEZES_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(win[CTRL_ADDR][HOLD_BIT]) && !$past(reg_we)) |-> $stable(win[SEC_ADDR])); // R5

    AST_STOP_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(win[SEC_ADDR][STOP_BIT]) && !$past(load_pend)) |-> $stable(cnt)); // R8

    AST_LOAD_TAKES_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(load_pend) && $past(tick)) |-> (cnt[1] == ($past(win[SEC_ADDR]) & 8'h7F))); // R7

    AST_SNAPSHOT_ON_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(reg_we) && (win[SEC_ADDR] != $past(win[SEC_ADDR]))) |-> (win[1] == 8'h00)); // R4

    AST_SECOND_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(advance) && $past(cnt[0]) == 8'h99 && $past(cnt[1]) == 8'h59) |-> (cnt[1] == 8'h00)); // R2

endmodule

bind bcd_rtc_core rtc_core_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .tick      (tick_100hz),
    .advance   (advance),
    .load_pend (load_pend_q),
    .win       (win_q),
    .cnt       (cnt_q)
);

// File: tb/bcd_rtc_core_tb.sv
module bcd_rtc_core_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_100hz = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_we = 1'b0;
    logic       reg_re = 1'b0;
    logic [7:0] reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_rtc_core u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_100hz (tick_100hz),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_we     (reg_we),
        .reg_re     (reg_re),
        .reg_rdata  (reg_rdata)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [3:0] a, input logic [7:0] exp);
        @(negedge clk);
        reg_addr = a; reg_re = 1'b1;
        #1;
        check(req, reg_rdata, exp);
        reg_re = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            tick_100hz = 1'b1;
            @(negedge clk);
            tick_100hz = 1'b0;
        end
    endtask

    task automatic t_reset;
        rd_check("R1 hundredths", 4'd1, 8'h00);
        rd_check("R1 seconds", 4'd9, 8'h00);
        rd_check("R1 hours", 4'd11, 8'h00);
        rd_check("R1 weekday", 4'd12, 8'h01);
        rd_check("R1 date", 4'd13, 8'h01);
        rd_check("R1 month", 4'd14, 8'h01);
        rd_check("R1 control", 4'd8, 8'h00);
        rd_check("R1 offset 5", 4'd5, 8'h00);
    endtask

    task automatic t_second_refresh;
        ticks(99);
        rd_check("R4 no refresh before second", 4'd9, 8'h00);
        rd_check("R4 hundredths not live", 4'd1, 8'h00);
        ticks(1);
        rd_check("R4 refresh at second", 4'd9, 8'h01);
        rd_check("R4 hundredths after refresh", 4'd1, 8'h00);
    endtask

    task automatic t_read_hold;
        wr(4'd8, 8'h40);
        ticks(100);
        rd_check("R5 frozen copy", 4'd9, 8'h01);
        wr(4'd8, 8'h00);
        ticks(100);
        rd_check("R5 counters kept running", 4'd9, 8'h03);
    endtask

    task automatic t_hold_collision;
        ticks(99);
        @(negedge clk);
        tick_100hz = 1'b1; reg_addr = 4'd8; reg_wdata = 8'h40; reg_we = 1'b1;
        @(negedge clk);
        tick_100hz = 1'b0; reg_we = 1'b0;
        rd_check("R6 refresh completes first", 4'd9, 8'h04);
        ticks(100);
        rd_check("R6 freeze afterwards", 4'd9, 8'h04);
        wr(4'd8, 8'h00);
        ticks(100);
        rd_check("R6 resume", 4'd9, 8'h06);
    endtask

    task automatic t_set_time;
        wr(4'd8, 8'h80);
        wr(4'd1, 8'h00);
        wr(4'd9, 8'h58);
        wr(4'd10, 8'hD9);
        wr(4'd11, 8'h23);
        wr(4'd12, 8'hA7);
        wr(4'd13, 8'h31);
        wr(4'd14, 8'h12);
        wr(4'd15, 8'h99);
        ticks(100);
        rd_check("R7 written value held", 4'd9, 8'h58);
        wr(4'd8, 8'h00);
        ticks(1);
        ticks(100);
        rd_check("R7 loaded and counting", 4'd9, 8'h59);
        rd_check("R9 minute spare kept", 4'd10, 8'hD9);
        ticks(100);
        rd_check("R2 seconds wrap", 4'd9, 8'h00);
        rd_check("R2 minutes wrap R9 spare", 4'd10, 8'h80);
        rd_check("R2 hours wrap", 4'd11, 8'h00);
        rd_check("R3 weekday 7 to 1 R9 spare", 4'd12, 8'hA1);
        rd_check("R2 date wrap", 4'd13, 8'h01);
        rd_check("R2 month wrap", 4'd14, 8'h01);
        rd_check("R2 year wrap", 4'd15, 8'h00);
    endtask

    task automatic t_osc_stop;
        wr(4'd9, 8'h80);
        ticks(200);
        rd_check("R8 no refresh while stopped", 4'd9, 8'h80);
        wr(4'd9, 8'h00);
        ticks(100);
        rd_check("R8 counters held while stopped", 4'd9, 8'h01);
        rd_check("R8 minutes unchanged", 4'd10, 8'h80);
    endtask

    task automatic t_storage_and_port;
        wr(4'd3, 8'h5A);
        wr(4'd0, 8'hC3);
        wr(4'd8, 8'h25);
        rd_check("R9 plain byte 3", 4'd3, 8'h5A);
        rd_check("R9 plain byte 0", 4'd0, 8'hC3);
        rd_check("R9 control low bits", 4'd8, 8'h25);
        ticks(100);
        rd_check("R9 control unaffected by refresh", 4'd8, 8'h25);
        rd_check("R9 refresh still runs", 4'd9, 8'h02);
        wr(4'd8, 8'h00);
        @(negedge clk);
        reg_addr = 4'd3; reg_re = 1'b0;
        #1;
        check("R10 read disabled gives zero", reg_rdata, 8'h00);
        rd_check("R10 read enabled", 4'd3, 8'h5A);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_second_refresh;
        t_read_hold;
        t_hold_collision;
        t_set_time;
        t_osc_stop;
        t_storage_and_port;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule